// File: doc/BRIEF.md
# Breaker Synchronism Check Supervisor

This block decides whether a circuit-breaker close may go ahead. Two check channels each supply comparison flags from an external measurement stage: voltage difference in band, frequency difference in band, phase angle difference in band, angle near zero and angle decreasing. A close request starts a check. The block then grants success, declares failure, or reports that the check is bypassed. Its outputs stay where they are until the request is withdrawn, and withdrawing the request returns the block to idle.

The block has two ways to qualify. The synchronous path needs the three difference flags of one enabled channel to be true together, without a break, for a programmable dwell time. The asynchronous path is used when the two networks are split. It needs a channel to report that the angle is near zero and still decreasing, so the close lands at phase coincidence. Both paths run under a separate failure timer. A blocking input suppresses success, and an external force input grants it at once.

Both times are set in steps of 100 ms and counted from a 1 ms tick. Each setting is captured when the close request arrives.

Top module: `sync_check_supervisor`

## Requirements
- R1: With the split-network enable low, a channel qualifies only while its voltage, frequency and angle difference flags are all high. When a channel qualifies from the request onward with the tick high on every cycle, `sync_ok` rises after clock edge D·TICKS_PER_STEP+2. Edges are counted with the edge that samples the request as edge 1, and D is the dwell setting in 100 ms steps.
- R2: If qualification drops for a cycle before the dwell elapses, the dwell restarts from zero. Success then comes D·TICKS_PER_STEP+1 edges after qualification returns.
- R3: With the split-network enable high, a channel qualifies when its angle-near-zero and angle-decreasing flags are both high, whatever the difference flags and the dwell setting. Success comes on edge 2.
- R4: When a channel's frequency-check enable is low, its frequency flag counts as satisfied.
- R5: Only channels whose use-enable bit is high can qualify. Any single enabled channel that qualifies is enough.
- R6: If the check enable is low when the request arrives, `bypass` rises on edge 1 and `sync_ok` stays low.
- R7: While the blocking input is high, `sync_ok` is low, and this holds even after success has been reached. Blocking also stops qualification and the force input.
- R8: If no success is reached, `sync_fail` rises after edge F·TICKS_PER_STEP+2, where F is the failure setting. Success takes priority if both fall due on the same edge.
- R9: A high force input while checking, with no blocking, gives success on edge 2.
- R10: At most one of `sync_ok`, `sync_fail` and `bypass` is high at any time. Each is held while the request stays high, and all three are low one edge after the request falls.
- R11: The dwell and failure settings are sampled when the request arrives. Later changes to them have no effect on the check in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| check_en | input | 1 | Check enable; low means bypass |
| split_en | input | 1 | Asynchronous (split network) mode |
| close_req | input | 1 | Close request, held high for the attempt |
| block_in | input | 1 | Blocks success |
| force_ok | input | 1 | External force of success |
| ch_use | input | NCH | Per-channel use enable |
| ch_df_en | input | NCH | Per-channel frequency-check enable |
| ch_dv_ok | input | NCH | Voltage difference in band |
| ch_df_ok | input | NCH | Frequency difference in band |
| ch_da_ok | input | NCH | Angle difference in band |
| ch_ang_zero | input | NCH | Angle near zero |
| ch_ang_dec | input | NCH | Angle decreasing |
| dwell_set | input | DWELL_W | Dwell in 100 ms steps (0..1000) |
| fail_set | input | FAIL_W | Failure timeout in 100 ms steps (0..18000) |
| sync_ok | output | 1 | Sync success |
| sync_fail | output | 1 | Sync failed |
| bypass | output | 1 | Check bypassed |

## Verification
The assertions check on every cycle that the three indications never overlap, that blocking keeps success low, that release clears the outputs on the next edge, that bypass rises only from a request made with the check disabled, and that a failure holds while the request does. The bench scenarios are the only place that shows the timing relations: the exact dwell and timeout edge counts, the dwell restart, the asynchronous path ignoring the dwell, channel and frequency-enable masking, and the capture of the settings at the request. It runs these against randomized dwell values and channel choices.

// File: rtl/sync_chk_pkg.sv
package sync_chk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SUCCESS,
        ST_FAILED,
        ST_BYPASS
    } sc_state_e;

    typedef struct packed {
        logic dv;
        logic df;
        logic da;
        logic zero;
        logic dec;
    } chan_flags_t;

    function automatic logic chan_sync_ok(chan_flags_t f, logic df_en);
        return f.dv && f.da && (f.df || !df_en);
    endfunction

    function automatic logic chan_async_ok(chan_flags_t f);
        return f.zero && f.dec;
    endfunction

endpackage

// File: rtl/sync_chk_qual.sv
module sync_chk_qual
    import sync_chk_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           split_en,
    input  logic [NCH-1:0] use_en,
    input  logic [NCH-1:0] df_en,
    input  chan_flags_t    flags [NCH],
    output logic           qualified
);

    logic [NCH-1:0] chan_hit;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_comb begin
            if (split_en)
                chan_hit[c] = use_en[c] && chan_async_ok(flags[c]);
            else
                chan_hit[c] = use_en[c] && chan_sync_ok(flags[c], df_en[c]);
        end
    end

    assign qualified = |chan_hit;

endmodule

// File: rtl/sync_step_timer.sv
module sync_step_timer #(
    parameter int TICKS_PER_STEP = 100,
    parameter int W              = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);

    localparam int PW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_STEP - 1);

    logic [PW-1:0] pre;
    logic [W-1:0]  steps;

    assign done = (steps >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre   <= '0;
            steps <= '0;
        end else if (tick && !done) begin
            if (pre == PRE_LAST) begin
                pre   <= '0;
                steps <= steps + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sync_check_supervisor.sv
module sync_check_supervisor
    import sync_chk_pkg::*;
#(
    parameter int NCH            = 2,
    parameter int TICKS_PER_STEP = 100,
    parameter int DWELL_W        = 10,
    parameter int FAIL_W         = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_1ms,
    input  logic               check_en,
    input  logic               split_en,
    input  logic               close_req,
    input  logic               block_in,
    input  logic               force_ok,
    input  logic [NCH-1:0]     ch_use,
    input  logic [NCH-1:0]     ch_df_en,
    input  logic [NCH-1:0]     ch_dv_ok,
    input  logic [NCH-1:0]     ch_df_ok,
    input  logic [NCH-1:0]     ch_da_ok,
    input  logic [NCH-1:0]     ch_ang_zero,
    input  logic [NCH-1:0]     ch_ang_dec,
    input  logic [DWELL_W-1:0] dwell_set,
    input  logic [FAIL_W-1:0]  fail_set,
    output logic               sync_ok,
    output logic               sync_fail,
    output logic               bypass
);

    sc_state_e          state, state_nx;
    chan_flags_t        flags [NCH];
    logic [DWELL_W-1:0] dwell_q;
    logic [FAIL_W-1:0]  fail_q;
    logic               qual, qual_ok, dwell_done, fail_done, in_check;

    for (genvar c = 0; c < NCH; c++) begin : g_pack
        assign flags[c] = '{dv:   ch_dv_ok[c],  df:  ch_df_ok[c],
                            da:   ch_da_ok[c],  zero: ch_ang_zero[c],
                            dec:  ch_ang_dec[c]};
    end

    sync_chk_qual #(.NCH(NCH)) u_qual (
        .split_en  (split_en),
        .use_en    (ch_use),
        .df_en     (ch_df_en),
        .flags     (flags),
        .qualified (qual)
    );

    assign in_check = (state == ST_CHECK);
    assign qual_ok  = qual && !block_in;

    sync_step_timer #(.TICKS_PER_STEP(TICKS_PER_STEP), .W(DWELL_W)) u_dwell (
        .clk   (clk),
        .rst   (rst),
        .clr   (!in_check || !qual_ok),
        .tick  (tick_1ms),
        .limit (dwell_q),
        .done  (dwell_done)
    );

    sync_step_timer #(.TICKS_PER_STEP(TICKS_PER_STEP), .W(FAIL_W)) u_fail (
        .clk   (clk),
        .rst   (rst),
        .clr   (!in_check),
        .tick  (tick_1ms),
        .limit (fail_q),
        .done  (fail_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_q <= '0;
            fail_q  <= '0;
        end else if (state == ST_IDLE && close_req) begin
            dwell_q <= dwell_set;
            fail_q  <= fail_set;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (close_req)
                    state_nx = check_en ? ST_CHECK : ST_BYPASS;
            end
            ST_CHECK: begin
                if (!close_req)
                    state_nx = ST_IDLE;
                else if (force_ok && !block_in)
                    state_nx = ST_SUCCESS;
                else if (qual_ok && (split_en || dwell_done))
                    state_nx = ST_SUCCESS;
                else if (fail_done)
                    state_nx = ST_FAILED;
            end
            ST_SUCCESS, ST_FAILED, ST_BYPASS: begin
                if (!close_req)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign sync_ok   = (state == ST_SUCCESS) && !block_in;
    assign sync_fail = (state == ST_FAILED);
    assign bypass    = (state == ST_BYPASS);

endmodule

// File: rtl/sync_check_sva.sv
module sync_check_sva (
    input logic clk,
    input logic rst,
    input logic check_en,
    input logic close_req,
    input logic block_in,
    input logic sync_ok,
    input logic sync_fail,
    input logic bypass
);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({sync_ok, sync_fail, bypass}) <= 1);

    assert_release_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !close_req |=> !sync_ok && !sync_fail && !bypass);

    assert_block_suppress_R7: assert property (@(posedge clk) disable iff (rst)
        block_in |-> !sync_ok);

    assert_bypass_origin_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass) |-> $past(close_req && !check_en));

    assert_fail_held_R8: assert property (@(posedge clk) disable iff (rst)
        sync_fail && close_req |=> sync_fail);

endmodule

bind sync_check_supervisor sync_check_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .check_en  (check_en),
    .close_req (close_req),
    .block_in  (block_in),
    .sync_ok   (sync_ok),
    .sync_fail (sync_fail),
    .bypass    (bypass)
);

// File: tb/tb_sync_check_supervisor.sv
module tb_sync_check_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;
    localparam int NCH        = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b1;
    logic check_en, split_en, close_req, block_in, force_ok;
    logic [NCH-1:0] ch_use, ch_df_en, ch_dv_ok, ch_df_ok, ch_da_ok, ch_ang_zero, ch_ang_dec;
    logic [9:0]  dwell_set;
    logic [14:0] fail_set;
    logic sync_ok, sync_fail, bypass;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_check_supervisor #(.NCH(NCH), .TICKS_PER_STEP(TPS)) dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .check_en(check_en),
        .split_en(split_en), .close_req(close_req), .block_in(block_in),
        .force_ok(force_ok), .ch_use(ch_use), .ch_df_en(ch_df_en),
        .ch_dv_ok(ch_dv_ok), .ch_df_ok(ch_df_ok), .ch_da_ok(ch_da_ok),
        .ch_ang_zero(ch_ang_zero), .ch_ang_dec(ch_ang_dec),
        .dwell_set(dwell_set), .fail_set(fail_set),
        .sync_ok(sync_ok), .sync_fail(sync_fail), .bypass(bypass)
    );

    // Outcome codes: 0 success, 1 failed, 2 bypass, 3 none
    function automatic int outcome();
        if (sync_ok)   return 0;
        if (sync_fail) return 1;
        if (bypass)    return 2;
        return 3;
    endfunction

    function automatic int expect_timed(int steps, int extra);
        return steps * TPS + extra;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic defaults();
        check_en = 1; split_en = 0; close_req = 0; block_in = 0; force_ok = 0;
        ch_use = '1; ch_df_en = '1; ch_dv_ok = '0; ch_df_ok = '0; ch_da_ok = '0;
        ch_ang_zero = '0; ch_ang_dec = '0; dwell_set = 10'd2; fail_set = 15'd50;
    endtask

    task automatic set_sync(int ch);
        ch_dv_ok[ch] = 1; ch_df_ok[ch] = 1; ch_da_ok[ch] = 1;
    endtask

    // Raise request, count edges until an indication appears
    task automatic attempt(output int code, output int edges);
        @(negedge clk); close_req = 1;
        code = 3; edges = -1;
        for (int n = 1; n <= 3000; n++) begin
            @(posedge clk); #1;
            if (outcome() != 3) begin code = outcome(); edges = n; break; end
        end
    endtask

    task automatic release_req();
        @(negedge clk); close_req = 0;
        @(posedge clk); #1;
        check("R10 release", outcome(), 3);
        @(negedge clk); defaults();
    endtask

    task automatic run(string req, int exp_code, int exp_edges);
        int code, edges;
        attempt(code, edges);
        check({req, " outcome"}, code, exp_code);
        check({req, " edges"}, edges, exp_edges);
        release_req();
    endtask

    initial begin
        int code, edges, d, ch;
        void'($urandom(32'h5A17));
        defaults();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check("reset outputs idle", outcome(), 3);

        // R1: synchronous dwell, channel 0
        set_sync(0); dwell_set = 3;
        run("R1 dwell 3", 0, expect_timed(3, 2));
        set_sync(1); dwell_set = 0;
        run("R1 dwell 0", 0, 2);

        // R2: dwell restart after a one-cycle drop
        dwell_set = 2;
        @(negedge clk); close_req = 1;
        @(negedge clk); set_sync(0);
        repeat (5) @(negedge clk);
        ch_dv_ok[0] = 0;
        @(negedge clk); ch_dv_ok[0] = 1;
        edges = -1;
        for (int n = 1; n <= 100; n++) begin
            @(posedge clk); #1;
            if (sync_ok) begin edges = n; break; end
        end
        check("R2 restart edges", edges, expect_timed(2, 1));
        release_req();

        // R3: asynchronous mode ignores dwell and difference flags
        split_en = 1; dwell_set = 9; ch_ang_zero[1] = 1; ch_ang_dec[1] = 1;
        run("R3 angle closure", 0, 2);
        split_en = 1; set_sync(0); fail_set = 2;
        run("R3 diff flags not enough", 1, expect_timed(2, 2));

        // R4: frequency-check enable
        ch_dv_ok[0] = 1; ch_da_ok[0] = 1; ch_df_en[0] = 0; dwell_set = 1;
        run("R4 df disabled", 0, expect_timed(1, 2));
        ch_dv_ok[0] = 1; ch_da_ok[0] = 1; fail_set = 1;
        run("R4 df enabled and low", 1, expect_timed(1, 2));

        // R5: channel use enable
        set_sync(1); ch_use = 2'b01; fail_set = 1;
        run("R5 unused channel", 1, expect_timed(1, 2));
        set_sync(1); ch_use = 2'b10; dwell_set = 0;
        run("R5 other channel", 0, 2);

        // R6: bypass
        check_en = 0; set_sync(0); dwell_set = 0;
        run("R6 bypass", 2, 1);

        // R7: blocking
        set_sync(0); block_in = 1; fail_set = 2; force_ok = 1;
        run("R7 blocked", 1, expect_timed(2, 2));
        set_sync(0); dwell_set = 0;
        attempt(code, edges);
        check("R7 pre-block success", code, 0);
        @(negedge clk); block_in = 1; #1;
        check("R7 held success suppressed", int'(sync_ok), 0);
        @(negedge clk); block_in = 0; #1;
        check("R7 success returns", int'(sync_ok), 1);
        release_req();

        // R8: timeout, and success priority on tie
        fail_set = 3;
        run("R8 timeout", 1, expect_timed(3, 2));
        set_sync(0); dwell_set = 2; fail_set = 2;
        run("R8 tie gives success", 0, expect_timed(2, 2));

        // R9: force
        force_ok = 1; dwell_set = 7;
        run("R9 force", 0, 2);

        // R10: hold while request stays high
        fail_set = 0;
        attempt(code, edges);
        repeat (20) @(posedge clk);
        #1 check("R10 fail held", outcome(), 1);
        release_req();

        // R11: settings sampled at request
        set_sync(0); dwell_set = 1;
        @(negedge clk); close_req = 1;
        @(negedge clk); dwell_set = 6; fail_set = 0;
        edges = 1;
        for (int n = 2; n <= 100; n++) begin
            @(posedge clk); #1;
            if (outcome() != 3) begin edges = n; break; end
        end
        check("R11 latched dwell", edges, expect_timed(1, 2));
        check("R11 outcome", outcome(), 0);
        release_req();

        // Random synchronous dwell runs (R1, R5)
        for (int i = 0; i < 20; i++) begin
            d  = int'($urandom_range(0, 5));
            ch = int'($urandom_range(0, 1));
            dwell_set = 10'(d); set_sync(ch);
            ch_use = 2'b00; ch_use[ch] = 1'b1;
            if ($urandom_range(0, 1) == 1) begin ch_df_en[ch] = 0; ch_df_ok[ch] = 0; end
            run("R1 random", 0, expect_timed(d, 2));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule